// File: doc/BRIEF.md
# Video Memory DMA Step Sequencer

This block paces DMA transfers into video memory, one step per access slot. Software-side logic loads a source address, a transfer length, a destination address, an address stride and a command code in a single arm cycle. The block then waits for slot strobes. On each strobe it decides whether this slot may carry a DMA step. A step updates every transfer register in the same clock and either writes a new entry into a small write ring or re-arms the last ring entry.

The bit pair `src_o[23:22]` picks the transfer kind. When bit 23 is clear, the step copies from the system bus into video memory. Each step writes a fresh entry that carries a ready time. The value `2'b10` selects fill. In fill mode a step only re-arms the entry just behind the write pointer, so that the drain side writes the same data again at the next address. The drain logic is outside this block. It only shows up here as a `pop_i` strobe that retires the head entry.

Top module: `vdma_sequencer`

## Requirements
- R1: After a synchronous active-low reset, the state is as follows. The run flag, code, source, length, destination and both ring pointers are zero. The ring is empty. The head entry fields are zero.
- R2: An arm strobe loads source, length, destination, stride and code from the load inputs and sets the run flag. An arm in the same cycle as a slot strobe loads and takes no step.
- R3: Each step adds one to source bits 7:0. Source bits 15:8 gain one only when bits 7:0 wrap from 8'hFF to 8'h00. Bits 23:16 never change except on arm.
- R4: Each step adds the 8-bit stride to the destination, modulo 2^ADDR_W.
- R5: Each step lowers the 16-bit length by one. When the new length is zero, the run flag clears and code bits 5:4 clear while bits 3:0 stay.
- R6: Mode decode is as follows. `src_o[23]`=0 means bus transfer, for both values of bit 22. `src_o[23:22]`=2'b10 means fill. 2'b11 takes no step.
- R7: In bus mode, a slot marked as refresh takes no step and writes no entry.
- R8: A bus step writes an entry at the write pointer. Its address is the destination before the step. Its partial count is 0. Its ready time is `now_i` plus 16×LAT_MULT when `wide_i`=1, or plus 20×LAT_MULT otherwise. The write pointer then advances modulo FIFO_DEPTH. If the ring was empty, the read pointer takes the old write pointer.
- R9: In bus mode, no step is taken while the ring is full, that is, while it is not empty and the write pointer equals the read pointer.
- R10: In fill mode, a step happens only on an external slot with the ring empty. The read pointer becomes the write pointer minus one. That entry is rewritten with ready time `now_i`, the destination before the step, and partial count 2. The ring becomes non-empty and the write pointer does not move.
- R11: At most one step is taken per slot strobe. No step is taken without a strobe or while the run flag is clear.
- R12: A pop on a non-empty ring advances the read pointer. The ring becomes empty when the read pointer reaches the write pointer. A pop on an empty ring is ignored. A bus step and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | Load all transfer fields and start |
| ld_src_i | input | 24 | Source address to load (bits 23:22 pick the mode) |
| ld_len_i | input | 16 | Transfer length to load |
| ld_dst_i | input | ADDR_W | Destination address to load |
| ld_stride_i | input | 8 | Destination stride to load |
| ld_code_i | input | 6 | Command code to load |
| slot_i | input | 1 | Access slot strobe |
| slot_ext_i | input | 1 | The current slot is an external slot |
| slot_refresh_i | input | 1 | The current slot is a refresh slot |
| wide_i | input | 1 | Wide display mode (shorter latency) |
| now_i | input | CYC_W | Current cycle count |
| pop_i | input | 1 | Drain side retires the head entry |
| run_o | output | 1 | Transfer in progress |
| code_o | output | 6 | Current command code |
| src_o | output | 24 | Current source address |
| len_o | output | 16 | Remaining length |
| dst_o | output | ADDR_W | Current destination address |
| empty_o | output | 1 | Write ring empty |
| wr_ptr_o | output | log2(FIFO_DEPTH) | Ring write pointer |
| rd_ptr_o | output | log2(FIFO_DEPTH) | Ring read pointer |
| head_cycle_o | output | CYC_W | Ready time of the head entry |
| head_addr_o | output | ADDR_W | Address of the head entry |
| head_partial_o | output | 2 | Partial count of the head entry |

## Verification
A bus step and a drain pop can land on the same clock edge. The bench provokes this twice. In the first case the ring is full, so the pop frees a place but the step is still refused because the full test uses the state before the edge. In the second case the ring is partly filled and both pointers advance while the ring stays non-empty. A fill re-arm and a pop cannot coincide usefully, because the re-arm needs an empty ring. That case is judged by a pop that empties the ring, so that the next external slot re-arms. A scoreboard compares every pointer, flag and head field after each edge.

// File: rtl/vdma_pkg.sv
// Shared types for the video-memory DMA sequencer.
// Assumes the mode sits in the top two bits of the source address.
package vdma_pkg;

    typedef enum logic [1:0] {
        MODE_BUS  = 2'd0,
        MODE_FILL = 2'd1,
        MODE_NONE = 2'd2
    } dma_mode_e;

    localparam logic [1:0] PART_BUS  = 2'd0;
    localparam logic [1:0] PART_FILL = 2'd2;
    localparam int         LAT_WIDE  = 16;
    localparam int         LAT_NARROW = 20;

    // Map the two mode bits to a transfer kind.
    function automatic dma_mode_e decode_mode(input logic [1:0] sel);
        if (!sel[1])            return MODE_BUS;
        else if (sel == 2'b10)  return MODE_FILL;
        else                    return MODE_NONE;
    endfunction

endpackage

// File: rtl/vdma_step_ctrl.sv
// Decides per slot strobe whether a DMA step happens and of which kind.
// Assumes the ring state inputs reflect the state before the coming edge.
module vdma_step_ctrl
    import vdma_pkg::*;
(
    input  logic       run_i,
    input  logic [1:0] mode_sel_i,
    input  logic       arm_i,
    input  logic       slot_i,
    input  logic       slot_ext_i,
    input  logic       slot_refresh_i,
    input  logic       ring_empty_i,
    input  logic       ring_full_i,
    output logic       push_o,
    output logic       rearm_o,
    output logic       step_o
);

    dma_mode_e mode;
    logic      live;

    // Qualify the slot, then pick bus push or fill re-arm.
    always_comb begin
        mode    = decode_mode(mode_sel_i);
        live    = slot_i && run_i && !arm_i;
        push_o  = live && (mode == MODE_BUS) && !slot_refresh_i && !ring_full_i;
        rearm_o = live && (mode == MODE_FILL) && slot_ext_i && ring_empty_i;
        step_o  = push_o || rearm_o;
    end

endmodule

// File: rtl/vdma_regs.sv
// Transfer registers: source, length, destination, stride, code, run flag.
// Assumes step_i and arm_i are never both high (the controller masks steps on arm).
module vdma_regs #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [23:0]       ld_src_i,
    input  logic [15:0]       ld_len_i,
    input  logic [ADDR_W-1:0] ld_dst_i,
    input  logic [7:0]        ld_stride_i,
    input  logic [5:0]        ld_code_i,
    input  logic              step_i,
    output logic              run_o,
    output logic [5:0]        code_o,
    output logic [23:0]       src_o,
    output logic [15:0]       len_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [7:0]        stride_o
);

    logic [15:0] len_next;

    // Remaining length after one step.
    always_comb len_next = len_o - 16'd1;

    // Load on arm, advance every field on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o    <= 1'b0;
            code_o   <= '0;
            src_o    <= '0;
            len_o    <= '0;
            dst_o    <= '0;
            stride_o <= '0;
        end else if (arm_i) begin
            run_o    <= 1'b1;
            code_o   <= ld_code_i;
            src_o    <= ld_src_i;
            len_o    <= ld_len_i;
            dst_o    <= ld_dst_i;
            stride_o <= ld_stride_i;
        end else if (step_i) begin
            src_o[7:0] <= src_o[7:0] + 8'd1;
            if (src_o[7:0] == 8'hFF)
                src_o[15:8] <= src_o[15:8] + 8'd1;
            dst_o <= dst_o + ADDR_W'(stride_o);
            len_o <= len_next;
            if (len_next == 16'd0) begin
                run_o  <= 1'b0;
                code_o <= {2'b00, code_o[3:0]};
            end
        end
    end

endmodule

// File: rtl/vdma_ring.sv
// Write ring: entry storage, read/write pointers and an empty flag.
// Assumes DEPTH is a power of two; pointers wrap by their own width.
module vdma_ring #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int CYC_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic                     rearm_i,
    input  logic                     pop_i,
    input  logic [CYC_W-1:0]         ent_cycle_i,
    input  logic [ADDR_W-1:0]        ent_addr_i,
    input  logic [1:0]               ent_part_i,
    output logic                     empty_o,
    output logic                     full_o,
    output logic [$clog2(DEPTH)-1:0] wr_ptr_o,
    output logic [$clog2(DEPTH)-1:0] rd_ptr_o,
    output logic [CYC_W-1:0]         head_cycle_o,
    output logic [ADDR_W-1:0]        head_addr_o,
    output logic [1:0]               head_part_o
);

    localparam int PW = $clog2(DEPTH);

    logic [CYC_W-1:0]  cyc_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [1:0]        part_q [DEPTH];
    logic [PW-1:0]     behind;
    logic [PW-1:0]     widx;
    logic              pop_ok;

    // Derived ring conditions and the slot an entry write targets.
    always_comb begin
        behind = wr_ptr_o - PW'(1);
        widx   = rearm_i ? behind : wr_ptr_o;
        pop_ok = pop_i && !empty_o;
        full_o = !empty_o && (wr_ptr_o == rd_ptr_o);
    end

    // Head entry as seen by the drain side.
    always_comb begin
        head_cycle_o = cyc_q[rd_ptr_o];
        head_addr_o  = addr_q[rd_ptr_o];
        head_part_o  = part_q[rd_ptr_o];
    end

    // Entry storage, written by a bus push or a fill re-arm.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cyc_q[g]  <= '0;
                    addr_q[g] <= '0;
                    part_q[g] <= '0;
                end else if ((push_i || rearm_i) && (widx == PW'(g))) begin
                    cyc_q[g]  <= ent_cycle_i;
                    addr_q[g] <= ent_addr_i;
                    part_q[g] <= ent_part_i;
                end
            end
        end
    endgenerate

    // Pointer and empty-flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_o <= '0;
            rd_ptr_o <= '0;
            empty_o  <= 1'b1;
        end else if (rearm_i) begin
            rd_ptr_o <= behind;
            empty_o  <= 1'b0;
        end else begin
            if (push_i && empty_o)
                rd_ptr_o <= wr_ptr_o;
            else if (pop_ok)
                rd_ptr_o <= rd_ptr_o + PW'(1);
            if (push_i) begin
                wr_ptr_o <= wr_ptr_o + PW'(1);
                empty_o  <= 1'b0;
            end else if (pop_ok && (rd_ptr_o + PW'(1) == wr_ptr_o)) begin
                empty_o  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vdma_sequencer.sv
// Top: DMA step sequencer into video memory, bus-transfer and fill modes.
// Assumes one slot strobe per slot; drain logic is outside and only pops.
module vdma_sequencer
    import vdma_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int ADDR_W     = 16,
    parameter int CYC_W      = 16,
    parameter int LAT_MULT   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          arm_i,
    input  logic [23:0]                   ld_src_i,
    input  logic [15:0]                   ld_len_i,
    input  logic [ADDR_W-1:0]             ld_dst_i,
    input  logic [7:0]                    ld_stride_i,
    input  logic [5:0]                    ld_code_i,
    input  logic                          slot_i,
    input  logic                          slot_ext_i,
    input  logic                          slot_refresh_i,
    input  logic                          wide_i,
    input  logic [CYC_W-1:0]              now_i,
    input  logic                          pop_i,
    output logic                          run_o,
    output logic [5:0]                    code_o,
    output logic [23:0]                   src_o,
    output logic [15:0]                   len_o,
    output logic [ADDR_W-1:0]             dst_o,
    output logic                          empty_o,
    output logic [$clog2(FIFO_DEPTH)-1:0] wr_ptr_o,
    output logic [$clog2(FIFO_DEPTH)-1:0] rd_ptr_o,
    output logic [CYC_W-1:0]              head_cycle_o,
    output logic [ADDR_W-1:0]             head_addr_o,
    output logic [1:0]                    head_partial_o
);

    localparam logic [CYC_W-1:0] LAT_W = CYC_W'(LAT_WIDE * LAT_MULT);
    localparam logic [CYC_W-1:0] LAT_N = CYC_W'(LAT_NARROW * LAT_MULT);

    logic              push, rearm, step, ring_full;
    logic [7:0]        stride;
    logic [CYC_W-1:0]  ent_cycle;
    logic [1:0]        ent_part;

    // Entry contents: ready time and partial count depend on the step kind.
    always_comb begin
        ent_cycle = rearm ? now_i : now_i + (wide_i ? LAT_W : LAT_N);
        ent_part  = rearm ? PART_FILL : PART_BUS;
    end

    vdma_step_ctrl u_ctrl (
        .run_i          (run_o),
        .mode_sel_i     (src_o[23:22]),
        .arm_i          (arm_i),
        .slot_i         (slot_i),
        .slot_ext_i     (slot_ext_i),
        .slot_refresh_i (slot_refresh_i),
        .ring_empty_i   (empty_o),
        .ring_full_i    (ring_full),
        .push_o         (push),
        .rearm_o        (rearm),
        .step_o         (step)
    );

    vdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm_i),
        .ld_src_i    (ld_src_i),
        .ld_len_i    (ld_len_i),
        .ld_dst_i    (ld_dst_i),
        .ld_stride_i (ld_stride_i),
        .ld_code_i   (ld_code_i),
        .step_i      (step),
        .run_o       (run_o),
        .code_o      (code_o),
        .src_o       (src_o),
        .len_o       (len_o),
        .dst_o       (dst_o),
        .stride_o    (stride)
    );

    vdma_ring #(.DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .rearm_i      (rearm),
        .pop_i        (pop_i),
        .ent_cycle_i  (ent_cycle),
        .ent_addr_i   (dst_o),
        .ent_part_i   (ent_part),
        .empty_o      (empty_o),
        .full_o       (ring_full),
        .wr_ptr_o     (wr_ptr_o),
        .rd_ptr_o     (rd_ptr_o),
        .head_cycle_o (head_cycle_o),
        .head_addr_o  (head_addr_o),
        .head_part_o  (head_partial_o)
    );

endmodule

// File: rtl/vdma_sva.sv
// Property checker for vdma_sequencer, attached through bind below.
// Assumes it observes the top's internal step, push and re-arm decisions.
module vdma_sva #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_i,
    input logic              slot_refresh_i,
    input logic              step,
    input logic              push,
    input logic              rearm,
    input logic              ring_full,
    input logic              empty_o,
    input logic              run_o,
    input logic [5:0]        code_o,
    input logic [23:0]       src_o,
    input logic [15:0]       len_o,
    input logic [ADDR_W-1:0] dst_o,
    input logic [7:0]        stride
);

    AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> $stable(src_o[23:16])); // R3

    AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && src_o[7:0] != 8'hFF) |=> $stable(src_o[15:8])); // R3

    AST_DST_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> dst_o == ($past(dst_o) + ADDR_W'($past(stride)))); // R4

    AST_LEN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> len_o == $past(len_o) - 16'd1); // R5

    AST_RUN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (step && len_o == 16'd1) |=> (!run_o && code_o[5:4] == 2'b00)); // R5

    AST_NO_REFRESH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        slot_refresh_i |-> !push); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> !push); // R9

    AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |-> empty_o); // R10

    AST_FILL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !empty_o); // R10

    AST_IDLE_NOSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> !step); // R11

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, rearm})); // R11

endmodule

bind vdma_sequencer vdma_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .arm_i          (arm_i),
    .slot_refresh_i (slot_refresh_i),
    .step           (step),
    .push           (push),
    .rearm          (rearm),
    .ring_full      (ring_full),
    .empty_o        (empty_o),
    .run_o          (run_o),
    .code_o         (code_o),
    .src_o          (src_o),
    .len_o          (len_o),
    .dst_o          (dst_o),
    .stride         (stride)
);

// File: tb/vdma_sequencer_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: tick() predicts the next state from the requirements and
// queues it; a monitor process compares the ports against each queued item.
module vdma_sequencer_tb_top;

    localparam int DEPTH = 4;

    typedef struct packed {
        logic        run;
        logic [5:0]  code;
        logic [23:0] src;
        logic [15:0] len;
        logic [15:0] dst;
        logic        empty;
        logic [1:0]  wr;
        logic [1:0]  rd;
        logic [15:0] hcyc;
        logic [15:0] haddr;
        logic [1:0]  hpart;
    } snap_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0, slot = 1'b0, ext = 1'b0, refr = 1'b0, wide = 1'b0, pop = 1'b0;
    logic [23:0] ld_src = '0;
    logic [15:0] ld_len = '0, ld_dst = '0, now_c = 16'd100;
    logic [7:0]  ld_stride = '0;
    logic [5:0]  ld_code = '0;

    logic        run_o, empty_o;
    logic [5:0]  code_o;
    logic [23:0] src_o;
    logic [15:0] len_o, dst_o, head_cycle_o, head_addr_o;
    logic [1:0]  wr_ptr_o, rd_ptr_o, head_partial_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    snap_t q_exp[$];
    string q_tag[$];

    // Model state
    logic        m_run = 1'b0, m_empty = 1'b1;
    logic [5:0]  m_code = '0;
    logic [23:0] m_src = '0;
    logic [15:0] m_len = '0, m_dst = '0;
    logic [7:0]  m_stride = '0;
    logic [1:0]  m_wr = '0, m_rd = '0;
    logic [15:0] m_cyc [DEPTH];
    logic [15:0] m_addr [DEPTH];
    logic [1:0]  m_part [DEPTH];

    always #10 clk = ~clk;

    vdma_sequencer #(.FIFO_DEPTH(DEPTH), .ADDR_W(16), .CYC_W(16), .LAT_MULT(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .ld_src_i(ld_src), .ld_len_i(ld_len),
        .ld_dst_i(ld_dst), .ld_stride_i(ld_stride), .ld_code_i(ld_code),
        .slot_i(slot), .slot_ext_i(ext), .slot_refresh_i(refr), .wide_i(wide),
        .now_i(now_c), .pop_i(pop), .run_o(run_o), .code_o(code_o), .src_o(src_o),
        .len_o(len_o), .dst_o(dst_o), .empty_o(empty_o), .wr_ptr_o(wr_ptr_o),
        .rd_ptr_o(rd_ptr_o), .head_cycle_o(head_cycle_o), .head_addr_o(head_addr_o),
        .head_partial_o(head_partial_o)
    );

    function automatic snap_t model_snap();
        snap_t s;
        s = '{m_run, m_code, m_src, m_len, m_dst, m_empty, m_wr, m_rd,
              m_cyc[m_rd], m_addr[m_rd], m_part[m_rd]};
        return s;
    endfunction

    // Driver: predict the effect of the staged inputs, clock once, queue it.
    task automatic tick(input string tag);
        logic live, bus, fill, full, push, rearm, popv, last;
        logic [1:0] wr0, rd0;
        live  = slot && m_run && !arm;
        bus   = !m_src[23];
        fill  = (m_src[23:22] == 2'b10);
        full  = !m_empty && (m_wr == m_rd);
        push  = live && bus && !refr && !full;
        rearm = live && fill && ext && m_empty;
        popv  = pop && !m_empty;
        wr0 = m_wr; rd0 = m_rd;
        if (arm) begin
            m_src = ld_src; m_len = ld_len; m_dst = ld_dst;
            m_stride = ld_stride; m_code = ld_code; m_run = 1'b1;
        end else if (push || rearm) begin
            if (push) begin
                m_cyc[wr0]  = now_c + (wide ? 16'd48 : 16'd60);
                m_addr[wr0] = m_dst;
                m_part[wr0] = 2'd0;
            end else begin
                m_cyc[wr0 - 2'd1]  = now_c;
                m_addr[wr0 - 2'd1] = m_dst;
                m_part[wr0 - 2'd1] = 2'd2;
            end
            if (m_src[7:0] == 8'hFF) m_src[15:8] = m_src[15:8] + 8'd1;
            m_src[7:0] = m_src[7:0] + 8'd1;
            m_dst = m_dst + {8'd0, m_stride};
            m_len = m_len - 16'd1;
            last  = (m_len == 16'd0);
            if (last) begin m_run = 1'b0; m_code[5:4] = 2'b00; end
        end
        if (rearm) begin
            m_rd = wr0 - 2'd1; m_empty = 1'b0;
        end else begin
            if (push && m_empty) m_rd = wr0;
            else if (popv) m_rd = rd0 + 2'd1;
            if (push) begin m_wr = wr0 + 2'd1; m_empty = 1'b0; end
            else if (popv && (rd0 + 2'd1 == wr0)) m_empty = 1'b1;
        end
        @(posedge clk);
        #1;
        q_exp.push_back(model_snap());
        q_tag.push_back(tag);
        arm = 1'b0; slot = 1'b0; ext = 1'b0; refr = 1'b0; pop = 1'b0;
        now_c = now_c + 16'd5;
    endtask

    task automatic load(input logic [23:0] s, input logic [15:0] l, input logic [15:0] d,
                        input logic [7:0] st, input logic [5:0] c);
        ld_src = s; ld_len = l; ld_dst = d; ld_stride = st; ld_code = c; arm = 1'b1;
    endtask

    // Monitor: compare ports with the oldest expected item, away from the edge.
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            snap_t e, a;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = '{run_o, code_o, src_o, len_o, dst_o, empty_o, wr_ptr_o, rd_ptr_o,
                  head_cycle_o, head_addr_o, head_partial_o};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", t, a, e);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_cyc[i] = '0; m_addr[i] = '0; m_part[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        q_exp.push_back(model_snap()); q_tag.push_back("R1 reset state");
        rst_n = 1'b1;
        @(posedge clk); #1;

        wide = 1'b1;
        load(24'h4012FE, 16'd3, 16'h0100, 8'd2, 6'h21); tick("R2 arm load, R6 bit22 set still bus");
        slot = 1; tick("R3 R4 R5 R8 first bus push, wide latency");
        slot = 1; refr = 1; tick("R7 refresh slot takes no step");
        wide = 1'b0;
        slot = 1; tick("R3 low byte wrap carries into middle, R8 narrow latency");
        slot = 1; tick("R5 length reaches zero, run and code[5:4] cleared");
        slot = 1; tick("R11 no step while run clear");

        load(24'h0000A0, 16'd4, 16'hFFFF, 8'd2, 6'h3A); tick("R2 rearm bus");
        slot = 1; tick("R4 destination wraps, R9 ring becomes full");
        slot = 1; tick("R9 full ring blocks the step");
        slot = 1; pop = 1; tick("R9 R12 pop frees space, step still refused same cycle");
        slot = 1; pop = 1; tick("R12 push and pop in one cycle");
        pop = 1; tick("R12 pop");
        pop = 1; tick("R12 pop");
        pop = 1; tick("R12 pop to empty");
        pop = 1; tick("R12 pop on empty ignored");

        load(24'h803000, 16'd2, 16'h0200, 8'd1, 6'h25); tick("R2 arm fill");
        slot = 1; tick("R10 fill waits for external slot");
        slot = 1; ext = 1; tick("R10 fill re-arms entry behind write pointer");
        slot = 1; ext = 1; tick("R10 no fill step while ring not empty");
        pop = 1; tick("R12 drain the re-armed entry");
        slot = 1; ext = 1; tick("R10 R5 fill final step ends transfer");

        load(24'hC00000, 16'd5, 16'h0300, 8'd1, 6'h12); tick("R2 arm reserved mode");
        slot = 1; ext = 1; tick("R6 mode 2'b11 takes no step");
        slot = 1; tick("R6 mode 2'b11 ignores plain slot");

        load(24'h001000, 16'd2, 16'h0400, 8'd4, 6'h11); slot = 1;
        tick("R11 R2 arm wins over a slot in the same cycle");
        slot = 1; wide = 1; tick("R8 push after arm");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule